// File: doc/BRIEF.md
# Ethernet PHY Speed Mode Configuration Registers

This block keeps the speed setting of one port of a multi-rate Ethernet PHY. Software programs it through two 32-bit word registers. The sequencer command register has byte offset 0x2C0. It picks one of three settings: automatic 1G/10G detection, a fixed 10G line, or a fixed 1G line. The serial-gigabit (SGMII) register has byte offset 0x290. It refines the fixed-1G setting into SGMII at 10M, 100M or 1G, or into SGMII with auto-negotiation. The block merges both registers into one registered operating mode. It drives that mode as decoded flags and a line-rate code. It also raises a one-cycle request whenever the mode changes, so the reconfiguration sequencer knows to act. Both registers can be read back.

Writes that carry an encoding outside the defined set are dropped. Each one sets a sticky error flag, which software reads at bit 31 of the sequencer register. A value written to the SGMII register while the sequencer is not fixed at 1G is stored. It takes effect only once the sequencer is later fixed at 1G.

Top module: `speed_mode_regs`

## Requirements
- R1: After reset, the sequencer register reads 0x0000_0001, the SGMII register reads 0, speedMode is 0 (auto), lineRate is 3 (10G), autoDetectEn is 1, sgmiiEn and sgmiiAnEn are 0, and modeChangeReq is 0.
- R2: Writing 0x11 to offset 0x2C0 fixes the port at 1G. With the SGMII register at 0, speedMode becomes 2 (1000BASE-X), lineRate becomes 2, and autoDetectEn becomes 0.
- R3: Writing 0x41 to offset 0x2C0 fixes the port at 10G. speedMode becomes 1, lineRate becomes 3, and sgmiiEn is 0.
- R4: Writing 0x01 to offset 0x2C0 restores automatic detection. speedMode becomes 0, lineRate becomes 3, and autoDetectEn becomes 1.
- R5: While the sequencer holds 0x11, the SGMII register selects the mode as follows. 0x01 gives speedMode 3 and lineRate 0 (10M). 0x05 gives speedMode 4 and lineRate 1 (100M). 0x09 gives speedMode 5 and lineRate 2. 0x03 gives speedMode 6 with sgmiiAnEn 1 and lineRate 2. 0x00 gives speedMode 2. sgmiiEn is 1 exactly for speedMode 3 to 6.
- R6: A valid SGMII write made while the sequencer is not 0x11 is stored and reads back, but speedMode does not change. A later write of 0x11 to the sequencer then applies the stored SGMII setting.
- R7: A write to either register whose 32-bit value is not one of that register's defined codes leaves that register unchanged. It also sets bit 31 of the sequencer readback. Bit 31 stays set until reset.
- R8: The mode outputs take the new value on the second rising clock edge after the edge that samples the write. modeChangeReq is high for exactly the cycle in which speedMode takes a new value. It stays low when a write leaves the mode unchanged.
- R9: Readback is combinational on regAddr. Offset 0x2C0 returns the code in bits 7:0 and the error flag in bit 31. Offset 0x290 returns the code in bits 7:0. All other bits, and all other offsets, read 0. Writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrite | input | 1 | Write strobe, sampled on a rising edge |
| regAddr | input | 12 | Byte offset for write and readback |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational readback of regAddr |
| speedMode | output | 3 | Operating mode: 0 auto, 1 10G, 2 1000BASE-X, 3 SGMII 10M, 4 SGMII 100M, 5 SGMII 1G, 6 SGMII auto-negotiation |
| lineRate | output | 2 | 0 10M, 1 100M, 2 1G, 3 10G |
| autoDetectEn | output | 1 | Automatic 1G/10G detection active |
| sgmiiEn | output | 1 | An SGMII mode is active |
| sgmiiAnEn | output | 1 | SGMII auto-negotiation active |
| modeChangeReq | output | 1 | One-cycle pulse when speedMode changes |

## Verification
The mode decode is driven with a walk through every sequencer command and every SGMII code. The walk includes a repeated code, which shows that the change pulse fires only on a real change and not on every write. SGMII codes are written while the port is fixed at 10G and then released by a 1G command. This separates storing a setting from applying it. Undefined codes on each register, writes to unmapped offsets, and a reset after an error separate rejected writes from accepted ones, and sticky error state from cleared error state.

// File: rtl/speed_mode_pkg.sv
package speed_mode_pkg;

  typedef enum logic [2:0] {
    MODE_AUTO   = 3'd0,
    MODE_10G    = 3'd1,
    MODE_1GX    = 3'd2,
    MODE_SG10M  = 3'd3,
    MODE_SG100M = 3'd4,
    MODE_SG1G   = 3'd5,
    MODE_SGAN   = 3'd6
  } speed_mode_e;

  typedef enum logic [1:0] {
    RATE_10M  = 2'd0,
    RATE_100M = 2'd1,
    RATE_1G   = 2'd2,
    RATE_10G  = 2'd3
  } line_rate_e;

  localparam int CODE_W = 8;

  // sequencer commands
  localparam logic [CODE_W-1:0] SEQ_AUTO     = 8'h01;
  localparam logic [CODE_W-1:0] SEQ_FORCE1G  = 8'h11;
  localparam logic [CODE_W-1:0] SEQ_FORCE10G = 8'h41;

  // serial-gigabit settings
  localparam logic [CODE_W-1:0] SG_OFF  = 8'h00;
  localparam logic [CODE_W-1:0] SG_10M  = 8'h01;
  localparam logic [CODE_W-1:0] SG_AN   = 8'h03;
  localparam logic [CODE_W-1:0] SG_100M = 8'h05;
  localparam logic [CODE_W-1:0] SG_1G   = 8'h09;

  // strobes from write decode to register datapath
  typedef struct packed {
    logic              seqLoad;
    logic              sgLoad;
    logic              errSet;
    logic [CODE_W-1:0] code;
  } cfg_strobe_t;

  function automatic logic seqCodeOk(input logic [CODE_W-1:0] c);
    return (c == SEQ_AUTO) || (c == SEQ_FORCE1G) || (c == SEQ_FORCE10G);
  endfunction

  function automatic logic sgCodeOk(input logic [CODE_W-1:0] c);
    return (c == SG_OFF) || (c == SG_10M) || (c == SG_AN) ||
           (c == SG_100M) || (c == SG_1G);
  endfunction

  function automatic speed_mode_e decodeMode(input logic [CODE_W-1:0] seq,
                                             input logic [CODE_W-1:0] sg);
    speed_mode_e m;
    m = MODE_AUTO;
    if (seq == SEQ_FORCE10G) begin
      m = MODE_10G;
    end else if (seq == SEQ_FORCE1G) begin
      case (sg)
        SG_10M:  m = MODE_SG10M;
        SG_100M: m = MODE_SG100M;
        SG_1G:   m = MODE_SG1G;
        SG_AN:   m = MODE_SGAN;
        default: m = MODE_1GX;
      endcase
    end
    return m;
  endfunction

  function automatic line_rate_e rateOf(input speed_mode_e m);
    line_rate_e r;
    case (m)
      MODE_SG10M:  r = RATE_10M;
      MODE_SG100M: r = RATE_100M;
      MODE_1GX, MODE_SG1G, MODE_SGAN: r = RATE_1G;
      default:     r = RATE_10G;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/speed_mode_ctrl.sv
module speed_mode_ctrl
  import speed_mode_pkg::*;
#(
  parameter int               ADDR_W   = 12,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SEQ_OFFS = 12'h2C0,
  parameter logic [ADDR_W-1:0] SG_OFFS  = 12'h290
) (
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output cfg_strobe_t       strobe
);

  localparam int HI_W = DATA_W - CODE_W;

  logic              seqHit;
  logic              sgHit;
  logic              upperClear;
  logic [CODE_W-1:0] lowCode;
  logic              seqGood;
  logic              sgGood;

  assign seqHit     = regWrite && (regAddr == SEQ_OFFS);
  assign sgHit      = regWrite && (regAddr == SG_OFFS);
  assign lowCode    = regWdata[CODE_W-1:0];
  assign upperClear = (regWdata[DATA_W-1:CODE_W] == {HI_W{1'b0}});
  assign seqGood    = upperClear && seqCodeOk(lowCode);
  assign sgGood     = upperClear && sgCodeOk(lowCode);

  always_comb begin
    strobe.seqLoad = seqHit && seqGood;
    strobe.sgLoad  = sgHit && sgGood;
    strobe.errSet  = (seqHit && !seqGood) || (sgHit && !sgGood);
    strobe.code    = lowCode;
  end

endmodule

// File: rtl/speed_mode_dp.sv
module speed_mode_dp
  import speed_mode_pkg::*;
#(
  parameter int               ADDR_W   = 12,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SEQ_OFFS = 12'h2C0,
  parameter logic [ADDR_W-1:0] SG_OFFS  = 12'h290
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [CODE_W-1:0] seqVal,
  output logic [CODE_W-1:0] sgVal,
  output logic              errSticky,
  output speed_mode_e       modeQ,
  output line_rate_e        rateQ,
  output logic              changeQ,
  output logic [DATA_W-1:0] regRdata
);

  localparam int ERR_BIT = DATA_W - 1;

  speed_mode_e nextMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqVal    <= SEQ_AUTO;
      sgVal     <= SG_OFF;
      errSticky <= 1'b0;
    end else begin
      if (strobe.seqLoad) seqVal <= strobe.code;
      if (strobe.sgLoad)  sgVal  <= strobe.code;
      if (strobe.errSet)  errSticky <= 1'b1;
    end
  end

  assign nextMode = decodeMode(seqVal, sgVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_AUTO;
      rateQ   <= RATE_10G;
      changeQ <= 1'b0;
    end else begin
      modeQ   <= nextMode;
      rateQ   <= rateOf(nextMode);
      changeQ <= (nextMode != modeQ);
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == SEQ_OFFS) begin
      regRdata[CODE_W-1:0] = seqVal;
      regRdata[ERR_BIT]    = errSticky;
    end else if (regAddr == SG_OFFS) begin
      regRdata[CODE_W-1:0] = sgVal;
    end
  end

endmodule

// File: rtl/speed_mode_regs.sv
module speed_mode_regs
  import speed_mode_pkg::*;
#(
  parameter int               ADDR_W   = 12,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SEQ_OFFS = 12'h2C0,
  parameter logic [ADDR_W-1:0] SG_OFFS  = 12'h290
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [2:0]        speedMode,
  output logic [1:0]        lineRate,
  output logic              autoDetectEn,
  output logic              sgmiiEn,
  output logic              sgmiiAnEn,
  output logic              modeChangeReq
);

  cfg_strobe_t       strobe;
  logic [CODE_W-1:0] seqVal;
  logic [CODE_W-1:0] sgVal;
  logic              errSticky;
  speed_mode_e       modeQ;
  line_rate_e        rateQ;

  speed_mode_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_OFFS(SEQ_OFFS), .SG_OFFS(SG_OFFS)
  ) u_ctrl (
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobe   (strobe)
  );

  speed_mode_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_OFFS(SEQ_OFFS), .SG_OFFS(SG_OFFS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regAddr   (regAddr),
    .seqVal    (seqVal),
    .sgVal     (sgVal),
    .errSticky (errSticky),
    .modeQ     (modeQ),
    .rateQ     (rateQ),
    .changeQ   (modeChangeReq),
    .regRdata  (regRdata)
  );

  assign speedMode    = modeQ;
  assign lineRate     = rateQ;
  assign autoDetectEn = (modeQ == MODE_AUTO);
  assign sgmiiEn      = (modeQ == MODE_SG10M) || (modeQ == MODE_SG100M) ||
                        (modeQ == MODE_SG1G)  || (modeQ == MODE_SGAN);
  assign sgmiiAnEn    = (modeQ == MODE_SGAN);

endmodule

// File: rtl/speed_mode_regs_chk.sv
module speed_mode_regs_chk #(
  parameter int               ADDR_W   = 12,
  parameter int               DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SEQ_OFFS = 12'h2C0
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [2:0]        speedMode,
  input logic [1:0]        lineRate,
  input logic              autoDetectEn,
  input logic              sgmiiEn,
  input logic              modeChangeReq,
  input logic [7:0]        seqVal,
  input logic              errSticky
);

  logic wr10g;
  logic wrAuto;
  assign wr10g  = regWrite && (regAddr == SEQ_OFFS) && (regWdata == 32'h41);
  assign wrAuto = regWrite && (regAddr == SEQ_OFFS) && (regWdata == 32'h01);

  // R8
  pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeChangeReq |-> (speedMode != $past(speedMode)));

  // R8
  quiet_when_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeChangeReq |-> $stable(speedMode));

  // R3
  force_10g_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wr10g, 2) |-> (speedMode == 3'd1 && lineRate == 2'd3));

  // R4
  back_to_auto_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrAuto, 2) |-> (speedMode == 3'd0 && autoDetectEn));

  // R6
  sgmii_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    sgmiiEn |-> ($past(seqVal) == 8'h11));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(errSticky) |-> errSticky);

endmodule

bind speed_mode_regs speed_mode_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_OFFS(SEQ_OFFS)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .regWrite      (regWrite),
  .regAddr       (regAddr),
  .regWdata      (regWdata),
  .speedMode     (speedMode),
  .lineRate      (lineRate),
  .autoDetectEn  (autoDetectEn),
  .sgmiiEn       (sgmiiEn),
  .modeChangeReq (modeChangeReq),
  .seqVal        (seqVal),
  .errSticky     (errSticky)
);

// File: tb/speed_mode_regs_tb.sv
module speed_mode_regs_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [11:0] A_SEQ = 12'h2C0;
  localparam logic [11:0] A_SG  = 12'h290;

  typedef struct packed {
    logic        toSg;
    logic [31:0] wdata;
    logic [2:0]  mode;
    logic [1:0]  rate;
    logic        pulse;
    logic [31:0] rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h11, 3'd2, 2'd2, 1'b1, 32'h11, 4'd2},        // R2
    '{1'b1, 32'h01, 3'd3, 2'd0, 1'b1, 32'h01, 4'd5},        // R5
    '{1'b1, 32'h05, 3'd4, 2'd1, 1'b1, 32'h05, 4'd5},        // R5
    '{1'b1, 32'h09, 3'd5, 2'd2, 1'b1, 32'h09, 4'd5},        // R5
    '{1'b1, 32'h03, 3'd6, 2'd2, 1'b1, 32'h03, 4'd5},        // R5
    '{1'b1, 32'h03, 3'd6, 2'd2, 1'b0, 32'h03, 4'd8},        // R8
    '{1'b1, 32'h00, 3'd2, 2'd2, 1'b1, 32'h00, 4'd5},        // R5
    '{1'b0, 32'h41, 3'd1, 2'd3, 1'b1, 32'h41, 4'd3},        // R3
    '{1'b1, 32'h05, 3'd1, 2'd3, 1'b0, 32'h05, 4'd6},        // R6
    '{1'b0, 32'h11, 3'd4, 2'd1, 1'b1, 32'h11, 4'd6},        // R6
    '{1'b0, 32'h01, 3'd0, 2'd3, 1'b1, 32'h01, 4'd4},        // R4
    '{1'b0, 32'h21, 3'd0, 2'd3, 1'b0, 32'h8000_0001, 4'd7}  // R7
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [2:0]  speedMode;
  logic [1:0]  lineRate;
  logic        autoDetectEn;
  logic        sgmiiEn;
  logic        sgmiiAnEn;
  logic        modeChangeReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  speed_mode_regs u_dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .speedMode(speedMode),
    .lineRate(lineRate), .autoDetectEn(autoDetectEn), .sgmiiEn(sgmiiEn),
    .sgmiiAnEn(sgmiiAnEn), .modeChangeReq(modeChangeReq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic chkMode(input string tag, input logic [2:0] m, input logic [1:0] r);
    chk(tag, "speedMode", {29'd0, speedMode}, {29'd0, m});
    chk(tag, "lineRate", {30'd0, lineRate}, {30'd0, r});
    chk(tag, "autoDetectEn", {31'd0, autoDetectEn}, {31'd0, m == 3'd0});
    chk(tag, "sgmiiEn", {31'd0, sgmiiEn}, {31'd0, (m >= 3'd3) && (m <= 3'd6)});
    chk(tag, "sgmiiAnEn", {31'd0, sgmiiAnEn}, {31'd0, m == 3'd6});
  endtask

  // returns at the falling edge after the write has been sampled
  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic readAt(input logic [11:0] a, input string tag, input logic [31:0] exp);
    regAddr = a;
    #1;
    chk(tag, "readback", regRdata, exp);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkMode("R1", 3'd0, 2'd3);
    chk("R1", "modeChangeReq", {31'd0, modeChangeReq}, 32'd0);
    readAt(A_SEQ, "R1", 32'h1);
    readAt(A_SG, "R1", 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      doWrite(VECS[i].toSg ? A_SG : A_SEQ, VECS[i].wdata);
      #1;
      chk(tag, "readback", regRdata, VECS[i].rd);         // R9
      @(negedge clk);
      chkMode(tag, VECS[i].mode, VECS[i].rate);
      chk(tag, "modeChangeReq", {31'd0, modeChangeReq}, {31'd0, VECS[i].pulse});
      @(negedge clk);
      chk("R8", "pulse width", {31'd0, modeChangeReq}, 32'd0);
    end

    // R7 undefined SGMII code keeps the stored 0x05
    doWrite(A_SG, 32'h07);
    readAt(A_SG, "R7", 32'h05);
    // R7 upper bits set make a sequencer code undefined
    doWrite(A_SEQ, 32'h0100_0041);
    readAt(A_SEQ, "R7", 32'h8000_0001);
    @(negedge clk);
    chkMode("R7", 3'd0, 2'd3);

    // R9 unmapped offset reads zero and ignores writes
    doWrite(12'h200, 32'h11);
    readAt(12'h200, "R9", 32'h0);
    @(negedge clk);
    chkMode("R9", 3'd0, 2'd3);
    chk("R9", "modeChangeReq", {31'd0, modeChangeReq}, 32'd0);
    readAt(A_SEQ, "R9", 32'h8000_0001);

    // R7 error stays after a valid write
    doWrite(A_SEQ, 32'h01);
    readAt(A_SEQ, "R7", 32'h8000_0001);

    // R1 reset clears all
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    readAt(A_SEQ, "R1", 32'h1);
    readAt(A_SG, "R1", 32'h0);
    chkMode("R1", 3'd0, 2'd3);

    finishRun();
  end

endmodule